// File: doc/BRIEF.md
# Doorbell-Driven Command Ring Fetcher

This block sits on the device side of a host/device command channel. It owns one register bank of 128 bytes. The bank holds two rings: a command ring and a response ring. For each ring, the host stores up to four page base addresses and a write pointer, then writes a doorbell register that carries the new target index. The ring's walker then reads 16-byte entries from memory. It starts at its last consumed index and stops when it reaches the target. Entries are read in one beat over a simple request/valid memory port.

The walker classifies each entry by bit 31 of its first word. An inline entry goes out on the command port as a code and a parameter. A host-memory reference goes out as a single DMA request that carries a bus address and a dword length. The walker then waits for a done pulse before it fetches the next entry. A read-only position register tracks the consumed index. A doorbell that arrives while a DMA reference is outstanding abandons that transfer and restarts the walk.

Top module: `ring_fetch_engine`

## Requirements
- R1: Register map, with bit 6 of the byte offset selecting the ring (0 = command ring, 1 = response ring). In-ring offset 0x00+8k holds the low half and 0x04+8k the high half of page k's base address (k = 0..3). Offset 0x20 holds the write pointer, 0x24 is the doorbell, and 0x28 holds the position. Page and write-pointer registers read back what was written. The doorbell reads as 0. A write to the position offset has no effect.
- R2: The entry at index i is fetched from address page_base[i[9:8]] + 16*i[7:0]. The 128-bit read data carries word0 in bits 31:0, word1 in bits 63:32, word2 in bits 95:64 and word3 in bits 127:96.
- R3: When word0 bit 31 is 0, the entry produces a one-cycle cmd_valid_o with cmd_code_o = word0 and cmd_param_o = word1.
- R4: When word0 bit 31 is 1, the entry produces exactly one one-cycle dma_req_o with dma_addr_o = {word3, word2} and dma_len_o = word0[30:0].
- R5: After a DMA request, the ring issues no memory read until dma_done_i arrives. The next entry is fetched only after that.
- R6: The position increases by exactly one per issued entry. For an inline entry it steps in the cycle cmd_valid_o is shown; for a DMA entry it steps on done. Once the ring is idle, the position equals the last doorbell value.
- R7: The index wraps from NPAGE*256-1 to 0.
- R8: A doorbell write whose value (bits 9:0) differs from the position starts a walk up to that value. A doorbell equal to the position starts no memory read and produces no output.
- R9: A doorbell written while a DMA reference is waiting for done pulses dma_abort_o for one cycle and leaves the position unchanged. The same entry is then fetched again and the walk continues to the new doorbell value.
- R10: Writing the write pointer alone starts no fetch.
- R11: The two rings use independent registers, positions and ports. Activity on one ring does not change the other ring's position.
- R12: After reset all positions and registers read 0, and every output strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Byte offset within the bank |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |
| mem_req_o | output | 2 | Entry read request per ring, held until valid |
| mem_addr_o | output | 2x64 | Entry address per ring |
| mem_rvalid_i | input | 2 | Entry read data valid per ring |
| mem_rdata_i | input | 2x128 | Entry data per ring |
| cmd_valid_o | output | 2 | Inline command strobe per ring |
| cmd_code_o | output | 2x32 | Inline command code |
| cmd_param_o | output | 2x32 | Inline command parameter |
| dma_req_o | output | 2 | DMA request strobe per ring |
| dma_addr_o | output | 2x64 | DMA bus address |
| dma_len_o | output | 2x31 | DMA length in dwords |
| dma_done_i | input | 2 | DMA completion pulse per ring |
| dma_abort_o | output | 2 | DMA abandoned by doorbell |

## Verification
The bench walks the command ring across a page boundary and through the wrap from index 511 to 0. A design with a wrong page select or wrap point fetches from the wrong address, and the scoreboard then sees the wrong codes. It holds back a DMA completion and rings the doorbell during the wait. A design that counted the abandoned entry, skipped the refetch or missed the abort pulse would shift every later item in the queue. It also writes the write pointer alone, repeats a doorbell that equals the position, and drives the response ring. An engine that starts on the wrong register or lets the rings interfere emits items that nothing expects.

// File: rtl/ring_fetch_pkg.sv
package ring_fetch_pkg;
  localparam int IDX_W        = 10;
  localparam int PAGE_ENTRIES = 256;
  localparam int MAX_PAGES    = 4;
  localparam int N_RINGS      = 2;

  typedef enum logic [1:0] {WK_IDLE, WK_FETCH, WK_DMA} walk_state_e;

  typedef struct packed {
    logic [31:0] w3;
    logic [31:0] w2;
    logic [31:0] w1;
    logic [31:0] w0;
  } ring_entry_t;
endpackage

// File: rtl/ring_bank_regs.sv
module ring_bank_regs
  import ring_fetch_pkg::*;
(
  input  logic                                      clk_i,
  input  logic                                      rst_ni,
  input  logic                                      reg_we_i,
  input  logic [6:0]                                reg_addr_i,
  input  logic [31:0]                               reg_wdata_i,
  output logic [31:0]                               reg_rdata_o,
  input  logic [N_RINGS-1:0][IDX_W-1:0]             pos_i,
  output logic [N_RINGS-1:0][MAX_PAGES-1:0][63:0]   page_base_o,
  output logic [N_RINGS-1:0]                        db_pulse_o,
  output logic [N_RINGS-1:0][IDX_W-1:0]             db_value_o
);
  localparam logic [5:0] OFF_WPTR = 6'h20;
  localparam logic [5:0] OFF_DB   = 6'h24;
  localparam logic [5:0] OFF_POS  = 6'h28;

  logic [5:0] off;
  logic       sel;
  assign off = reg_addr_i[5:0];
  assign sel = reg_addr_i[6];

  logic [N_RINGS-1:0][MAX_PAGES-1:0][63:0] page_q;
  logic [N_RINGS-1:0][31:0]                wptr_q;

  for (genvar r = 0; r < N_RINGS; r++) begin : g_ring
    logic hit;
    assign hit = reg_we_i && (sel == 1'(r));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        page_q[r] <= '0;
        wptr_q[r] <= '0;
      end else if (hit) begin
        if (!off[5]) begin
          if (off[2]) page_q[r][off[4:3]][63:32] <= reg_wdata_i;
          else        page_q[r][off[4:3]][31:0]  <= reg_wdata_i;
        end else if (off == OFF_WPTR) begin
          wptr_q[r] <= reg_wdata_i;
        end
      end
    end

    assign db_pulse_o[r]  = hit && (off == OFF_DB);
    assign db_value_o[r]  = reg_wdata_i[IDX_W-1:0];
    assign page_base_o[r] = page_q[r];

    // R10
    wptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !hit |=> $stable(wptr_q[r]));
  end

  always_comb begin
    reg_rdata_o = '0;
    if (!off[5]) begin
      reg_rdata_o = off[2] ? page_q[sel][off[4:3]][63:32] : page_q[sel][off[4:3]][31:0];
    end else if (off == OFF_WPTR) begin
      reg_rdata_o = wptr_q[sel];
    end else if (off == OFF_POS) begin
      reg_rdata_o = 32'(pos_i[sel]);
    end
  end
endmodule

// File: rtl/ring_walker.sv
module ring_walker
  import ring_fetch_pkg::*;
#(
  parameter int NPAGE = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        start_i,
  input  logic [IDX_W-1:0]            target_i,
  input  logic [MAX_PAGES-1:0][63:0]  page_base_i,
  output logic                        mem_req_o,
  output logic [63:0]                 mem_addr_o,
  input  logic                        mem_rvalid_i,
  input  logic [127:0]                mem_rdata_i,
  output logic                        cmd_valid_o,
  output logic [31:0]                 cmd_code_o,
  output logic [31:0]                 cmd_param_o,
  output logic                        dma_req_o,
  output logic [63:0]                 dma_addr_o,
  output logic [30:0]                 dma_len_o,
  input  logic                        dma_done_i,
  output logic                        dma_abort_o,
  output logic [IDX_W-1:0]            pos_o
);
  localparam int               RING_LEN = NPAGE * PAGE_ENTRIES;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(RING_LEN - 1);

  walk_state_e      state_q;
  logic [IDX_W-1:0] pos_q, tgt_q, tgt_n, pos_inc;
  ring_entry_t      ent;

  logic        cmd_valid_q, dma_req_q, abort_q;
  logic [31:0] code_q, param_q;
  logic [63:0] daddr_q;
  logic [30:0] dlen_q;

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] i);
    return (i == LAST_IDX) ? '0 : i + 1'b1;
  endfunction

  assign ent     = ring_entry_t'(mem_rdata_i);
  assign pos_inc = step(pos_q);
  assign tgt_n   = start_i ? target_i : tgt_q;

  assign mem_req_o  = (state_q == WK_FETCH);
  assign mem_addr_o = page_base_i[pos_q[9:8]] + 64'({pos_q[7:0], 4'h0});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= WK_IDLE;
      pos_q       <= '0;
      tgt_q       <= '0;
      cmd_valid_q <= 1'b0;
      dma_req_q   <= 1'b0;
      abort_q     <= 1'b0;
      code_q      <= '0;
      param_q     <= '0;
      daddr_q     <= '0;
      dlen_q      <= '0;
    end else begin
      cmd_valid_q <= 1'b0;
      dma_req_q   <= 1'b0;
      abort_q     <= 1'b0;
      tgt_q       <= tgt_n;
      unique case (state_q)
        WK_IDLE: if (start_i && target_i != pos_q) state_q <= WK_FETCH;
        WK_FETCH: begin
          if (tgt_n == pos_q) begin
            state_q <= WK_IDLE;       // retargeted onto current slot
          end else if (mem_rvalid_i) begin
            if (ent.w0[31]) begin
              dma_req_q <= 1'b1;
              daddr_q   <= {ent.w3, ent.w2};
              dlen_q    <= ent.w0[30:0];
              state_q   <= WK_DMA;
            end else begin
              cmd_valid_q <= 1'b1;
              code_q      <= ent.w0;
              param_q     <= ent.w1;
              pos_q       <= pos_inc;
              state_q     <= (pos_inc == tgt_n) ? WK_IDLE : WK_FETCH;
            end
          end
        end
        WK_DMA: begin
          if (start_i) begin
            abort_q <= 1'b1;           // transfer abandoned, slot refetched
            state_q <= (target_i == pos_q) ? WK_IDLE : WK_FETCH;
          end else if (dma_done_i) begin
            pos_q   <= pos_inc;
            state_q <= (pos_inc == tgt_q) ? WK_IDLE : WK_FETCH;
          end
        end
        default: state_q <= WK_IDLE;
      endcase
    end
  end

  assign cmd_valid_o = cmd_valid_q;
  assign cmd_code_o  = code_q;
  assign cmd_param_o = param_q;
  assign dma_req_o   = dma_req_q;
  assign dma_addr_o  = daddr_q;
  assign dma_len_o   = dlen_q;
  assign dma_abort_o = abort_q;
  assign pos_o       = pos_q;

  // R3
  inline_class_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> !cmd_code_o[31]);
  // R4
  dma_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |=> !dma_req_o);
  // R5
  no_read_in_dma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_req_o |-> !mem_req_o);
  // R6
  pos_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_q != $past(pos_q)) |-> (pos_q == step($past(pos_q))));
  // R6
  idle_at_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == WK_IDLE) |-> (pos_q == tgt_q));
  // R7
  pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q <= LAST_IDX);
  // R9
  abort_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dma_abort_o |-> $stable(pos_q));
endmodule

// File: rtl/ring_fetch_engine.sv
module ring_fetch_engine
  import ring_fetch_pkg::*;
#(
  parameter int NPAGE = 4
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        reg_we_i,
  input  logic [6:0]                  reg_addr_i,
  input  logic [31:0]                 reg_wdata_i,
  output logic [31:0]                 reg_rdata_o,
  output logic [N_RINGS-1:0]          mem_req_o,
  output logic [N_RINGS-1:0][63:0]    mem_addr_o,
  input  logic [N_RINGS-1:0]          mem_rvalid_i,
  input  logic [N_RINGS-1:0][127:0]   mem_rdata_i,
  output logic [N_RINGS-1:0]          cmd_valid_o,
  output logic [N_RINGS-1:0][31:0]    cmd_code_o,
  output logic [N_RINGS-1:0][31:0]    cmd_param_o,
  output logic [N_RINGS-1:0]          dma_req_o,
  output logic [N_RINGS-1:0][63:0]    dma_addr_o,
  output logic [N_RINGS-1:0][30:0]    dma_len_o,
  input  logic [N_RINGS-1:0]          dma_done_i,
  output logic [N_RINGS-1:0]          dma_abort_o
);
  logic [N_RINGS-1:0][IDX_W-1:0]           pos;
  logic [N_RINGS-1:0][MAX_PAGES-1:0][63:0] page_base;
  logic [N_RINGS-1:0]                      db_pulse;
  logic [N_RINGS-1:0][IDX_W-1:0]           db_value;

  ring_bank_regs u_regs (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .reg_rdata_o,
    .pos_i(pos), .page_base_o(page_base), .db_pulse_o(db_pulse), .db_value_o(db_value)
  );

  for (genvar r = 0; r < N_RINGS; r++) begin : g_walk
    ring_walker #(.NPAGE(NPAGE)) u_walk (
      .clk_i, .rst_ni,
      .start_i     (db_pulse[r]),
      .target_i    (db_value[r]),
      .page_base_i (page_base[r]),
      .mem_req_o   (mem_req_o[r]),
      .mem_addr_o  (mem_addr_o[r]),
      .mem_rvalid_i(mem_rvalid_i[r]),
      .mem_rdata_i (mem_rdata_i[r]),
      .cmd_valid_o (cmd_valid_o[r]),
      .cmd_code_o  (cmd_code_o[r]),
      .cmd_param_o (cmd_param_o[r]),
      .dma_req_o   (dma_req_o[r]),
      .dma_addr_o  (dma_addr_o[r]),
      .dma_len_o   (dma_len_o[r]),
      .dma_done_i  (dma_done_i[r]),
      .dma_abort_o (dma_abort_o[r]),
      .pos_o       (pos[r])
    );
  end

  // R12
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_o[0] && dma_req_o[0]));
endmodule

// File: tb/ring_fetch_engine_test.sv
`timescale 1ns/1ps
module ring_fetch_engine_test;
  localparam int NPG  = 2;
  localparam int RLEN = NPG * 256;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic              reg_we = 0;
  logic [6:0]        reg_addr = 0;
  logic [31:0]       reg_wdata = 0, reg_rdata;
  logic [1:0]        mem_req, mem_rvalid = 0, cmd_valid, dma_req, dma_done = 0, dma_abort;
  logic [1:0][63:0]  mem_addr, dma_addr;
  logic [1:0][127:0] mem_rdata = '0;
  logic [1:0][31:0]  cmd_code, cmd_param;
  logic [1:0][30:0]  dma_len;

  ring_fetch_engine #(.NPAGE(NPG)) uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(reg_we), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .cmd_valid_o(cmd_valid), .cmd_code_o(cmd_code), .cmd_param_o(cmd_param),
    .dma_req_o(dma_req), .dma_addr_o(dma_addr), .dma_len_o(dma_len),
    .dma_done_i(dma_done), .dma_abort_o(dma_abort)
  );

  typedef struct { logic dma; logic [63:0] a; logic [63:0] b; } exp_t;
  exp_t q0[$], q1[$];
  int checks = 0, fails = 0, aborts0 = 0;
  logic hold0 = 0, dma_seen0 = 0, finished = 0;
  logic [63:0] base [2][4];

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mem_fn(input logic [63:0] a);
    logic [31:0] w0;
    if (a[6:4] == 3'd5) w0 = {1'b1, 19'd0, a[15:4] + 12'd1};
    else                w0 = {1'b0, a[38:32], a[27:4]};
    return {a[63:32] + 32'd1, a[31:0] ^ 32'hA5A5_0000, ~a[31:0], w0};
  endfunction

  task automatic push_range(input int r, input int from, input int to);
    int i = from;
    while (i != to) begin
      logic [63:0] a; logic [127:0] e; exp_t x;
      a = base[r][i / 256] + 64'((i % 256) * 16);
      e = mem_fn(a);
      x.dma = e[31];
      x.a = e[31] ? e[127:64] : 64'(e[31:0]);
      x.b = e[31] ? 64'(e[30:0]) : 64'(e[63:32]);
      if (r == 0) q0.push_back(x); else q1.push_back(x);
      i = (i + 1) % RLEN;
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd_chk(input logic [6:0] a, input logic [31:0] exp, input string req);
    reg_addr = a; #1;
    chk(reg_rdata == exp, req, 64'(reg_rdata), 64'(exp));
  endtask

  task automatic wait_idle(input int r, input int tgt, input string req);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk); reg_addr = r ? 7'h68 : 7'h28; #1;
      if (((r == 0) ? q0.size() : q1.size()) == 0 && reg_rdata == tgt && !mem_req[r]) break;
    end
    chk(reg_rdata == tgt, req, 64'(reg_rdata), 64'(tgt));
    chk(((r == 0) ? q0.size() : q1.size()) == 0, req, 64'((r == 0) ? q0.size() : q1.size()), 0);
  endtask

  // memory model: 2-cycle read latency per ring
  initial begin
    int lat[2]; bit busy[2]; logic [63:0] ma[2];
    busy = '{0, 0};
    forever begin
      @(negedge clk);
      for (int r = 0; r < 2; r++) begin
        mem_rvalid[r] = 0;
        if (!busy[r]) begin
          if (mem_req[r]) begin busy[r] = 1; lat[r] = 2; ma[r] = mem_addr[r]; end
        end else begin
          lat[r]--;
          if (lat[r] == 0) begin busy[r] = 0; mem_rvalid[r] = 1; mem_rdata[r] = mem_fn(ma[r]); end
        end
      end
    end
  end

  // DMA completion model
  initial begin
    int cnt[2]; bit pend[2];
    pend = '{0, 0};
    forever begin
      @(negedge clk);
      for (int r = 0; r < 2; r++) begin
        dma_done[r] = 0;
        if (dma_req[r]) begin pend[r] = 1; cnt[r] = 0; end
        else if (pend[r]) begin
          cnt[r]++;
          if (cnt[r] >= 3 && !(r == 0 && hold0)) begin dma_done[r] = 1; pend[r] = 0; end
        end
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (dma_abort[0]) aborts0++;
      for (int r = 0; r < 2; r++) begin
        if (cmd_valid[r] || dma_req[r]) begin
          exp_t x; int n;
          n = (r == 0) ? q0.size() : q1.size();
          if (n == 0) begin
            chk(0, "R8/R10/R11 unexpected item", {cmd_valid[r], dma_req[r]}, 0);
          end else begin
            x = (r == 0) ? q0.pop_front() : q1.pop_front();
            if (dma_req[r]) begin
              if (r == 0) dma_seen0 = 1;
              chk(x.dma && dma_addr[r] == x.a && 64'(dma_len[r]) == x.b, "R4 dma ref",
                  dma_addr[r], x.a);
            end else begin
              chk(!x.dma && 64'(cmd_code[r]) == x.a && 64'(cmd_param[r]) == x.b, "R3 inline",
                  {cmd_code[r], cmd_param[r]}, {x.a[31:0], x.b[31:0]});
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      chk(0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    base[0][0] = 64'h0000_0012_3400_0000; base[0][1] = 64'h0000_0056_7800_0000;
    base[0][2] = '0; base[0][3] = '0;
    base[1][0] = 64'h0000_009A_0000_0000; base[1][1] = '0; base[1][2] = '0; base[1][3] = '0;
    repeat (3) @(negedge clk);
    // R12 reset state
    rd_chk(7'h28, 0, "R12 pos0");
    rd_chk(7'h68, 0, "R12 pos1");
    rd_chk(7'h00, 0, "R12 page");
    chk(mem_req == 0 && cmd_valid == 0 && dma_req == 0 && dma_abort == 0, "R12 strobes",
        {mem_req, cmd_valid, dma_req, dma_abort}, 0);
    rst_n = 1;
    // R1 programming and readback
    wr(7'h00, base[0][0][31:0]); wr(7'h04, base[0][0][63:32]);
    wr(7'h08, base[0][1][31:0]); wr(7'h0C, base[0][1][63:32]);
    wr(7'h40, base[1][0][31:0]); wr(7'h44, base[1][0][63:32]);
    rd_chk(7'h0C, base[0][1][63:32], "R1 page1 high");
    rd_chk(7'h44, base[1][0][63:32], "R1 ring1 page0 high");
    // R10 write pointer alone
    wr(7'h20, 32'd4);
    rd_chk(7'h20, 32'd4, "R1 wptr readback");
    repeat (20) @(negedge clk);
    chk(mem_req[0] == 0, "R10 no fetch", 64'(mem_req[0]), 0);
    rd_chk(7'h28, 0, "R10 pos");
    wr(7'h28, 32'h55);
    rd_chk(7'h28, 0, "R1 pos read-only");
    // R2/R3/R6 first walk
    push_range(0, 0, 4); wr(7'h24, 4); wr(7'h20, 4);
    wait_idle(0, 4, "R6 walk 0..4");
    rd_chk(7'h24, 0, "R1 doorbell reads 0");
    // R4/R5 walk across page boundary to 510
    push_range(0, 4, 510); wr(7'h24, 510);
    wait_idle(0, 510, "R2/R5 walk to 510");
    // R7 wrap
    push_range(0, 510, 3); wr(7'h24, 3);
    wait_idle(0, 3, "R7 wrap");
    // R9 abort during DMA wait
    hold0 = 1; dma_seen0 = 0;
    push_range(0, 3, 6); wr(7'h24, 6);
    while (!dma_seen0) @(negedge clk);
    repeat (2) @(negedge clk);
    dma_seen0 = 0;
    push_range(0, 5, 8); wr(7'h24, 8);
    rd_chk(7'h28, 5, "R9 pos unchanged");
    while (!dma_seen0) @(negedge clk);
    hold0 = 0;
    wait_idle(0, 8, "R9 refetch and continue");
    chk(aborts0 == 1, "R9 abort pulse", 64'(aborts0), 1);
    // R8 doorbell equal to position
    wr(7'h24, 8);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_req[0]) chk(0, "R8 no fetch", 1, 0);
    end
    rd_chk(7'h28, 8, "R8 pos");
    // R11 response ring
    push_range(1, 0, 7); wr(7'h64, 7);
    wait_idle(1, 7, "R11 ring1 walk");
    rd_chk(7'h28, 8, "R11 ring0 untouched");
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule